// File: doc/BRIEF.md
# Vectored Message Interrupt Controller

This block gathers a bank of device interrupt lines and converts each one that is pending, enabled for messaging and not masked into a vectored interrupt message. The message goes to an upstream vector controller and carries two bytes that software programs for that line: a vector number and a route selector. Software reaches the controller over a simple 32-bit register bus. The bus sets up per-line masking, message enable, trigger mode and polarity, and it acknowledges serviced lines through a write-one-to-clear register.

Each input passes through a two-flop synchronizer. It is then qualified as either a level or an edge of the selected polarity and held in a pending latch. After the line's message is accepted it stays in service until software acknowledges it. When several lines are waiting, the lowest-numbered one is sent first. Messages leave on a valid/ready port and stay stable while they are stalled.

Top module: `vmsg_intc`

## Requirements
- R1: After reset, msg_valid is 0 and both mask words read 0xFFFFFFFF. Message enable, edge select, polarity and the route and vector bytes read 0.
- R2: The per-line bit registers are two 32-bit words each, with line n at bit n%32 of word n/32 and the second word 4 bytes above the first. The offsets are mask 0x20, message enable 0x40, edge select 0x60, clear 0x80, two spare stored words 0xC0 and 0xE0, and polarity 0x3E0. The route byte of line n is at 0x100+n and its vector byte is at 0x200+n, packed little-endian, four to a word. Writes honour the four byte enables, reads return the stored values, and the clear words read 0.
- R3: A mask bit of 1 keeps its line from sending. A line that is masked while pending keeps its pending state and sends once the mask bit is cleared to 0.
- R4: A line whose message-enable bit is 0 sends no message.
- R5: With edge bit 1, polarity 0 picks rising edges and polarity 1 picks falling edges. The detected edge stays pending after the input returns.
- R6: With edge bit 0, polarity 0 means active-high and polarity 1 means active-low. A line that is still active when it is cleared raises a new message. A line that is inactive when cleared stays quiet.
- R7: Each pending event yields exactly one message. The line then stays in service, and edges or levels that arrive before its clear produce no message.
- R8: Writing 1 to a clear bit drops that line's pending and in-service state. Clear bits written as 0 have no effect.
- R9: When several lines are eligible, the one with the lowest index is sent first.
- R10: A message carries the line's vector byte on msg_vector and its route byte on msg_route. Both hold stable while msg_valid is 1 and msg_ready is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | LINES | Asynchronous device interrupt lines |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address of the 32-bit word |
| bus_be | input | 4 | Byte enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Upstream accepts the message |
| msg_vector | output | 8 | Vector byte of the sent line |
| msg_route | output | 8 | Route byte of the sent line |

## Verification
Each line gets a distinct vector and route, so the scoreboard can tell from every accepted message which line sent it. Both edge polarities and both level polarities are exercised. A held edge input is compared with a held level input across a clear, which separates latched edges from re-raising levels. Toggling a line that is in service, writing zero clear bits, and raising a masked or disabled line each must produce no message. Those cases separate the in-service, clear, mask and enable gating. Three lines raised together under back-pressure check both the lowest-index order and that the message holds stable while stalled.

// File: rtl/vmsg_pkg.sv
package vmsg_pkg;
  localparam int ADDR_W = 12;

  localparam logic [11:0] OFF_MASK  = 12'h020;
  localparam logic [11:0] OFF_MSGEN = 12'h040;
  localparam logic [11:0] OFF_EDGE  = 12'h060;
  localparam logic [11:0] OFF_CLR   = 12'h080;
  localparam logic [11:0] OFF_SPA   = 12'h0C0;
  localparam logic [11:0] OFF_SPB   = 12'h0E0;
  localparam logic [11:0] OFF_ROUTE = 12'h100;
  localparam logic [11:0] OFF_VEC   = 12'h200;
  localparam logic [11:0] OFF_POL   = 12'h3E0;

  // word address (byte address / 4) of the idx-th word above base
  function automatic logic [9:0] word_sel(logic [11:0] base, int idx);
    return base[11:2] + 10'(idx);
  endfunction

  function automatic logic [31:0] be_bits(logic [3:0] be);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[b*8 +: 8] = {8{be[b]}};
    return r;
  endfunction

  function automatic logic [31:0] be_merge(logic [31:0] old_v, logic [31:0] new_v,
                                           logic [3:0] be);
    return (old_v & ~be_bits(be)) | (new_v & be_bits(be));
  endfunction
endpackage

// File: rtl/vmsg_sync.sv
module vmsg_sync #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] now_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] st1, st2, st3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st1 <= '0;
      st2 <= '0;
      st3 <= '0;
    end else begin
      st1 <= din;
      st2 <= st1;
      st3 <= st2;
    end
  end

  assign now_o  = st2;
  assign prev_o = st3;
endmodule

// File: rtl/vmsg_regs.sv
module vmsg_regs
  import vmsg_pkg::*;
#(
  parameter int LINES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [LINES-1:0]  mask_o,
  output logic [LINES-1:0]  msgen_o,
  output logic [LINES-1:0]  edge_o,
  output logic [LINES-1:0]  pol_o,
  output logic [LINES-1:0]  eoi_o,
  output logic [LINES*8-1:0] route_o,
  output logic [LINES*8-1:0] vec_o
);
  localparam int WORDS  = LINES / 32;
  localparam int BWORDS = LINES / 4;

  logic [LINES-1:0] mask_q, msgen_q, edge_q, pol_q, spa_q, spb_q;
  logic [LINES*8-1:0] route_q, vec_q;
  logic wr;
  logic [9:0] wa;

  assign wr = bus_sel & bus_we;
  assign wa = bus_addr[11:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '1;
      msgen_q <= '0;
      edge_q  <= '0;
      pol_q   <= '0;
      spa_q   <= '0;
      spb_q   <= '0;
      route_q <= '0;
      vec_q   <= '0;
    end else if (wr) begin
      for (int w = 0; w < WORDS; w++) begin
        if (wa == word_sel(OFF_MASK, w))
          mask_q[w*32 +: 32] <= be_merge(mask_q[w*32 +: 32], bus_wdata, bus_be);
        if (wa == word_sel(OFF_MSGEN, w))
          msgen_q[w*32 +: 32] <= be_merge(msgen_q[w*32 +: 32], bus_wdata, bus_be);
        if (wa == word_sel(OFF_EDGE, w))
          edge_q[w*32 +: 32] <= be_merge(edge_q[w*32 +: 32], bus_wdata, bus_be);
        if (wa == word_sel(OFF_POL, w))
          pol_q[w*32 +: 32] <= be_merge(pol_q[w*32 +: 32], bus_wdata, bus_be);
        if (wa == word_sel(OFF_SPA, w))
          spa_q[w*32 +: 32] <= be_merge(spa_q[w*32 +: 32], bus_wdata, bus_be);
        if (wa == word_sel(OFF_SPB, w))
          spb_q[w*32 +: 32] <= be_merge(spb_q[w*32 +: 32], bus_wdata, bus_be);
      end
      for (int k = 0; k < BWORDS; k++) begin
        if (wa == word_sel(OFF_ROUTE, k))
          route_q[k*32 +: 32] <= be_merge(route_q[k*32 +: 32], bus_wdata, bus_be);
        if (wa == word_sel(OFF_VEC, k))
          vec_q[k*32 +: 32] <= be_merge(vec_q[k*32 +: 32], bus_wdata, bus_be);
      end
    end
  end

  // acknowledge pulses: only written ones, only for this cycle
  always_comb begin
    eoi_o = '0;
    for (int w = 0; w < WORDS; w++)
      if (wr && wa == word_sel(OFF_CLR, w))
        eoi_o[w*32 +: 32] = bus_wdata & be_bits(bus_be);
  end

  always_comb begin
    bus_rdata = '0;
    for (int w = 0; w < WORDS; w++) begin
      if (wa == word_sel(OFF_MASK, w))  bus_rdata = mask_q[w*32 +: 32];
      if (wa == word_sel(OFF_MSGEN, w)) bus_rdata = msgen_q[w*32 +: 32];
      if (wa == word_sel(OFF_EDGE, w))  bus_rdata = edge_q[w*32 +: 32];
      if (wa == word_sel(OFF_POL, w))   bus_rdata = pol_q[w*32 +: 32];
      if (wa == word_sel(OFF_SPA, w))   bus_rdata = spa_q[w*32 +: 32];
      if (wa == word_sel(OFF_SPB, w))   bus_rdata = spb_q[w*32 +: 32];
    end
    for (int k = 0; k < BWORDS; k++) begin
      if (wa == word_sel(OFF_ROUTE, k)) bus_rdata = route_q[k*32 +: 32];
      if (wa == word_sel(OFF_VEC, k))   bus_rdata = vec_q[k*32 +: 32];
    end
  end

  assign mask_o  = mask_q;
  assign msgen_o = msgen_q;
  assign edge_o  = edge_q;
  assign pol_o   = pol_q;
  assign route_o = route_q;
  assign vec_o   = vec_q;
endmodule

// File: rtl/vmsg_core.sv
module vmsg_core #(
  parameter int LINES = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LINES-1:0]   lvl_now,
  input  logic [LINES-1:0]   lvl_prev,
  input  logic [LINES-1:0]   mask,
  input  logic [LINES-1:0]   msgen,
  input  logic [LINES-1:0]   edge_sel,
  input  logic [LINES-1:0]   pol,
  input  logic [LINES-1:0]   eoi,
  input  logic [LINES*8-1:0] route_flat,
  input  logic [LINES*8-1:0] vec_flat,
  input  logic               msg_ready,
  output logic               msg_valid,
  output logic [7:0]         msg_vector,
  output logic [7:0]         msg_route,
  output logic [LINES-1:0]   pend_o,
  output logic [LINES-1:0]   insvc_o,
  output logic [LINES-1:0]   grant_o,
  output logic               load_o
);
  localparam int IDXW = $clog2(LINES);
  localparam logic [LINES-1:0] ONE = LINES'(1);

  logic [LINES-1:0] active, active_prev, edge_hit, trig;
  logic [LINES-1:0] pend_q, insvc_q, elig, grant, take;
  logic [IDXW-1:0]  idx;
  logic             load;

  // polarity applied to both samples so a polarity change is not an edge
  assign active      = lvl_now ^ pol;
  assign active_prev = lvl_prev ^ pol;
  assign edge_hit    = active & ~active_prev;
  assign trig        = (edge_sel & edge_hit) | (~edge_sel & active);

  assign elig  = pend_q & ~mask & msgen;
  assign grant = elig & (~elig + ONE);
  assign load  = (~msg_valid | msg_ready) & (|elig);
  assign take  = load ? grant : '0;

  always_comb begin
    idx = '0;
    for (int i = LINES - 1; i >= 0; i--)
      if (elig[i]) idx = IDXW'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      insvc_q <= '0;
    end else begin
      pend_q  <= (pend_q | (trig & ~insvc_q)) & ~take & ~eoi;
      insvc_q <= (insvc_q | take) & ~eoi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_valid  <= 1'b0;
      msg_vector <= '0;
      msg_route  <= '0;
    end else if (load) begin
      msg_valid  <= 1'b1;
      msg_vector <= vec_flat[idx*8 +: 8];
      msg_route  <= route_flat[idx*8 +: 8];
    end else if (msg_ready) begin
      msg_valid  <= 1'b0;
    end
  end

  assign pend_o  = pend_q;
  assign insvc_o = insvc_q;
  assign grant_o = grant;
  assign load_o  = load;
endmodule

// File: rtl/vmsg_intc.sv
module vmsg_intc
  import vmsg_pkg::*;
#(
  parameter int LINES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  irq_in,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [7:0]        msg_vector,
  output logic [7:0]        msg_route
);
  logic [LINES-1:0]   lvl_now, lvl_prev;
  logic [LINES-1:0]   mask_w, msgen_w, edge_w, pol_w, eoi_w;
  logic [LINES*8-1:0] route_w, vec_w;
  logic [LINES-1:0]   pend_w, insvc_w, grant_w;
  logic               load_w;

  vmsg_sync #(.W(LINES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(irq_in), .now_o(lvl_now), .prev_o(lvl_prev)
  );

  vmsg_regs #(.LINES(LINES)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .mask_o(mask_w), .msgen_o(msgen_w),
    .edge_o(edge_w), .pol_o(pol_w), .eoi_o(eoi_w),
    .route_o(route_w), .vec_o(vec_w)
  );

  vmsg_core #(.LINES(LINES)) u_core (
    .clk(clk), .rst_n(rst_n), .lvl_now(lvl_now), .lvl_prev(lvl_prev),
    .mask(mask_w), .msgen(msgen_w), .edge_sel(edge_w), .pol(pol_w),
    .eoi(eoi_w), .route_flat(route_w), .vec_flat(vec_w),
    .msg_ready(msg_ready), .msg_valid(msg_valid),
    .msg_vector(msg_vector), .msg_route(msg_route),
    .pend_o(pend_w), .insvc_o(insvc_w), .grant_o(grant_w), .load_o(load_w)
  );
endmodule

// File: rtl/vmsg_intc_chk.sv
module vmsg_intc_chk #(
  parameter int LINES = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             msg_valid,
  input logic             msg_ready,
  input logic [7:0]       msg_vector,
  input logic [7:0]       msg_route,
  input logic [LINES-1:0] mask,
  input logic [LINES-1:0] msgen,
  input logic [LINES-1:0] eoi,
  input logic [LINES-1:0] pend,
  input logic [LINES-1:0] insvc,
  input logic [LINES-1:0] grant,
  input logic             load
);
  localparam logic [LINES-1:0] ONE = LINES'(1);

  p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_vector) && $stable(msg_route));

  p_masked_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (grant & mask) == '0);

  p_disabled_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (grant & ~msgen) == '0);

  p_single_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  p_lowest_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (pend & ~mask & msgen & (grant - ONE)) == '0);

  p_no_resend_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (grant & insvc) == '0);

  p_enters_service_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load && ((grant & eoi) == '0) |=> (insvc & $past(grant)) == $past(grant));

  p_eoi_releases_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|eoi) |=> (insvc & $past(eoi)) == '0);
endmodule

bind vmsg_intc vmsg_intc_chk #(.LINES(LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_vector(msg_vector), .msg_route(msg_route), .mask(mask_w),
  .msgen(msgen_w), .eoi(eoi_w), .pend(pend_w), .insvc(insvc_w),
  .grant(grant_w), .load(load_w)
);

// File: tb/test_vmsg_intc.sv
module test_vmsg_intc;
  localparam int LINES = 64;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] irq_in;
  logic        bus_sel, bus_we;
  logic [11:0] bus_addr;
  logic [3:0]  bus_be;
  logic [31:0] bus_wdata, bus_rdata;
  logic        msg_valid, msg_ready;
  logic [7:0]  msg_vector, msg_route;

  always #10 clk = ~clk;

  vmsg_intc #(.LINES(LINES)) i_vmsg_intc (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_vector(msg_vector), .msg_route(msg_route)
  );

  int n_checks = 0;
  int n_fail   = 0;
  logic [15:0] exp_q[$];

  function automatic logic [7:0] vec_of(int n);   return 8'h40 + 8'(n); endfunction
  function automatic logic [7:0] route_of(int n); return 8'(n) ^ 8'hA5;  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic push(input int n);
    exp_q.push_back({vec_of(n), route_of(n)});
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d,
                           input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic read_check(input logic [11:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] d;
    bus_read(a, d);
    check(d == exp, tag, $sformatf("read 0x%03h", a), d, exp);
  endtask

  task automatic set_irq(input int n, input logic v);
    @(negedge clk);
    irq_in[n] = v;
    repeat (4) @(negedge clk);
  endtask

  // all expected messages must have been accepted, and no others
  task automatic settle(input string tag);
    repeat (12) @(negedge clk);
    check(exp_q.size() == 0, tag, "outstanding expected messages", exp_q.size(), 0);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n === 1'b1 && msg_valid && msg_ready) begin
        if (exp_q.size() == 0)
          check(1'b0, "R7", "unexpected message", {msg_vector, msg_route}, 0);
        else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          check({msg_vector, msg_route} == e, "R10", "message vector/route",
                {msg_vector, msg_route}, e);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] held;
    rst_n = 1'b0; irq_in = '0; bus_sel = 0; bus_we = 0; bus_addr = '0;
    bus_be = 4'hF; bus_wdata = '0; msg_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    check(msg_valid == 1'b0, "R1", "msg_valid after reset", msg_valid, 0);
    read_check(12'h020, 32'hFFFF_FFFF, "R1");
    read_check(12'h024, 32'hFFFF_FFFF, "R1");
    read_check(12'h040, 32'h0, "R1");
    read_check(12'h3E4, 32'h0, "R1");
    read_check(12'h204, 32'h0, "R1");

    // configuration through the register map (R2)
    bus_write(12'h020, 32'h0);
    bus_write(12'h024, 32'h0);
    bus_write(12'h080, 32'hFFFF_FFFF);
    bus_write(12'h084, 32'hFFFF_FFFF);
    for (int k = 0; k < 16; k++) begin
      bus_write(12'h100 + 12'(4*k), {route_of(4*k+3), route_of(4*k+2), route_of(4*k+1), route_of(4*k)});
      bus_write(12'h200 + 12'(4*k), {vec_of(4*k+3), vec_of(4*k+2), vec_of(4*k+1), vec_of(4*k)});
    end
    read_check(12'h208, {vec_of(11), vec_of(10), vec_of(9), vec_of(8)}, "R2");
    bus_write(12'h104, 32'hDEAD_BEEF, 4'b0100);
    read_check(12'h104, {route_of(7), 8'hAD, route_of(5), route_of(4)}, "R2");
    bus_write(12'h104, {8'h0, route_of(6), 16'h0}, 4'b0100);
    read_check(12'h104, {route_of(7), route_of(6), route_of(5), route_of(4)}, "R2");
    bus_write(12'h060, (32'h1 << 3) | (32'h1 << 5) | (32'h1 << 12) | (32'h1 << 20) | (32'h1 << 25));
    bus_write(12'h064, (32'h1 << 1) | (32'h1 << 8));
    read_check(12'h064, 32'h0000_0102, "R2");
    bus_write(12'h3E4, 32'h1 << 8);
    read_check(12'h3E4, 32'h0000_0100, "R2");
    bus_write(12'h0C4, 32'h1234_5678);
    read_check(12'h0C4, 32'h1234_5678, "R2");
    read_check(12'h080, 32'h0, "R2");
    bus_write(12'h040, ~(32'h1 << 25));
    bus_write(12'h044, 32'hFFFF_FFFF);
    settle("R2");

    // R5: rising edge on line 3
    push(3);
    set_irq(3, 1'b1);
    settle("R5");
    // R7: new edge while in service gives no message
    set_irq(3, 1'b0);
    set_irq(3, 1'b1);
    settle("R7");
    // R8: zero clear bits have no effect
    bus_write(12'h080, 32'h0);
    set_irq(3, 1'b0);
    set_irq(3, 1'b1);
    settle("R8");
    bus_write(12'h080, 32'h1 << 3);
    settle("R8");
    push(3);
    set_irq(3, 1'b0);
    set_irq(3, 1'b1);
    settle("R8");

    // R5: falling edge on line 40
    set_irq(40, 1'b1);
    settle("R5");
    push(40);
    set_irq(40, 1'b0);
    settle("R5");

    // R6: level active-high on line 10 re-raises after clear
    push(10);
    set_irq(10, 1'b1);
    settle("R6");
    push(10);
    bus_write(12'h080, 32'h1 << 10);
    settle("R6");
    set_irq(10, 1'b0);
    bus_write(12'h080, 32'h1 << 10);
    settle("R6");

    // R6: level active-low on line 50
    push(50);
    bus_write(12'h3E4, (32'h1 << 8) | (32'h1 << 18));
    settle("R6");
    set_irq(50, 1'b1);
    bus_write(12'h084, 32'h1 << 18);
    settle("R6");

    // R3: masked line holds pending, sends on unmask
    bus_write(12'h020, 32'h1 << 20);
    set_irq(20, 1'b1);
    settle("R3");
    push(20);
    bus_write(12'h020, 32'h0);
    settle("R3");

    // R4: disabled line 25 sends nothing
    set_irq(25, 1'b1);
    settle("R4");
    bus_write(12'h080, 32'h1 << 25);
    bus_write(12'h040, 32'hFFFF_FFFF);
    read_check(12'h040, 32'hFFFF_FFFF, "R4");
    settle("R4");

    // R9 and R10: simultaneous lines under back-pressure
    @(negedge clk);
    msg_ready = 1'b0;
    push(5); push(12); push(33);
    @(negedge clk);
    irq_in[5] = 1'b1; irq_in[12] = 1'b1; irq_in[33] = 1'b1;
    repeat (6) @(negedge clk);
    check(msg_valid == 1'b1, "R10", "msg_valid while stalled", msg_valid, 1);
    held = {msg_vector, msg_route};
    check(held == {vec_of(5), route_of(5)}, "R9", "first line stalled", held,
          {vec_of(5), route_of(5)});
    repeat (4) @(negedge clk);
    check({msg_vector, msg_route} == held && msg_valid, "R10", "stable while stalled",
          {msg_vector, msg_route}, held);
    msg_ready = 1'b1;
    settle("R9");

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule